// File: doc/BRIEF.md
# Idle Wake-Up Clock Enable Controller

This block decides which clock domains of a dual-processor chip run while the chip sits in a low-power idle state and when they come back. A host register write sets an idle-request bit. When no wake source is pending, the controller moves from RUN to IDLE and drops every clock enable. Several sources can bring clocks back: an interrupt to the host processor, an interrupt to the DSP, local-bus activity, and DMA requests from the memory traffic controller or from the peripheral bridge.

Interrupts wake the chip through a one-cycle WAKE state. That state enables only the domains that belong to the interrupting processor, and then the block returns to RUN. Bus and DMA activity do not leave IDLE. They hold on the enables of the domains they need for as long as the activity lasts. A wake-mode bit selects who controls a chip-wide wake. With the bit set, a single interrupt is enough. With the bit clear, interrupts are ignored in IDLE and only the strobe from an external low-power controller wakes the chip.

Only the host register port can write the idle-request and wake-mode bits. There is no write path from the DSP side.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset the state is RUN, `clk_en_o` is all ones, `periph_en_o` is all ones, and both `idle_req_o` and `wake_mode_o` are 0. The state code is RUN=0, IDLE=1, WAKE=2.
- R2: A cycle with `host_wr_i`=1 loads `host_wdata_i[0]` into the idle-request bit and `host_wdata_i[1]` into the wake-mode bit. Both are visible on the outputs one cycle later.
- R3: In RUN, if the idle-request bit is 1 and no wake source is pending, the next state is IDLE. A pending source is a synchronized interrupt or any active bus or DMA hold, and it keeps the block in RUN. In IDLE with no activity, `clk_en_o` and `periph_en_o` are 0.
- R4: In IDLE with wake-mode 1, a host interrupt reaches the state machine through two flops, and the block then enters WAKE on the following edge, three cycles after `host_irq_n_i` falls. WAKE enables `clk_en_o` bits 0 (host core), 1 (host interrupt controller), 2 (peripheral bridge), 3 (DMA) and 4 (traffic controller), drives `periph_en_o` = `periph_restore_i`, and clears the idle-request bit.
- R5: A DSP interrupt wake follows the same timing as a host interrupt. It enables bits 4, 6 (DSP core) and 7 (DSP interrupt controller), and also bit 8 (host-port interface) only when `hpi_en_i`=1. It drives `periph_en_o` = `periph_restore_i` and leaves the idle-request bit unchanged.
- R6: WAKE lasts exactly one cycle and is followed by RUN with all enables at 1.
- R7: With wake-mode 0, interrupts do not leave IDLE. Instead, `ulp_wake_i`=1 in IDLE enters WAKE on the next edge with every enable at 1 and clears the idle-request bit. With wake-mode 1, `ulp_wake_i` has no effect.
- R8: In IDLE, `lb_act_i`=1 turns on `clk_en_o` bits 4 and 5 (local bus) in the same cycle without leaving IDLE. The bits drop one cycle after `lb_act_i` falls.
- R9: In IDLE, a request on `dma_tc_req_i` turns on bits 3, 4 and 5. They stay on while `dma_busy_i`=1 and drop one cycle after it falls.
- R10: In IDLE, a request on `dma_br_req_i` turns on bits 2, 3 and 4. They stay on while `dma_busy_i`=1 and drop one cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_i | input | 1 | Host register write strobe |
| host_wdata_i | input | 2 | Bit 0 idle request, bit 1 wake mode |
| host_irq_n_i | input | 1 | Host interrupt, active low, asynchronous |
| dsp_irq_n_i | input | 1 | DSP interrupt, active low, asynchronous |
| lb_act_i | input | 1 | Local-bus activity enable |
| dma_tc_req_i | input | 1 | DMA request from the traffic controller |
| dma_br_req_i | input | 1 | DMA request from the peripheral bridge |
| dma_busy_i | input | 1 | DMA controller busy |
| ulp_wake_i | input | 1 | Wake strobe from the external low-power controller |
| hpi_en_i | input | 1 | Host-port interface clock enable setting |
| periph_restore_i | input | N_PERIPH | Peripheral enables restored on an interrupt wake |
| clk_en_o | output | 9 | Clock-domain enables, bit map as in R4, R5 and R8 |
| periph_en_o | output | N_PERIPH | Peripheral clock enables |
| state_o | output | 2 | Controller state |
| idle_req_o | output | 1 | Idle-request bit |
| wake_mode_o | output | 1 | Wake-mode bit |

## Verification
The bench drives a host interrupt and a DSP interrupt into IDLE. It runs the DSP case once with the host-port enable set and once with it clear, so that a swapped or missing domain bit and a misapplied host-port condition show up as different masks. Bus activity, DMA from the traffic controller and DMA from the bridge are each held for several cycles and then released, which separates the three hold masks and pins the one-cycle drop. Interrupts and the external strobe are applied under both wake-mode values, which shows whether the mode bit really moves wake authority. A DSP interrupt held through WAKE and a pending bus hold during an idle request exercise the rule that pending sources block entry to IDLE.

// File: rtl/iwk_pkg.sv
package iwk_pkg;
  localparam int DOM_W  = 9;
  localparam int D_HOST = 0;
  localparam int D_HINT = 1;
  localparam int D_BRG  = 2;
  localparam int D_DMA  = 3;
  localparam int D_TC   = 4;
  localparam int D_LB   = 5;
  localparam int D_DSP  = 6;
  localparam int D_DINT = 7;
  localparam int D_HPI  = 8;

  localparam int N_ACT    = 3;
  localparam int A_LB     = 0;
  localparam int A_DMA_TC = 1;
  localparam int A_DMA_BR = 2;

  typedef logic [DOM_W-1:0] dom_mask_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAKE = 2'd2
  } iwk_state_e;

  localparam dom_mask_t M_HOST_IRQ = (dom_mask_t'(1) << D_HOST) | (dom_mask_t'(1) << D_HINT) |
                                     (dom_mask_t'(1) << D_BRG)  | (dom_mask_t'(1) << D_DMA)  |
                                     (dom_mask_t'(1) << D_TC);
  localparam dom_mask_t M_DSP_IRQ  = (dom_mask_t'(1) << D_DSP) | (dom_mask_t'(1) << D_DINT) |
                                     (dom_mask_t'(1) << D_TC);
  localparam dom_mask_t M_HPI      = dom_mask_t'(1) << D_HPI;

  function automatic dom_mask_t act_mask(int unsigned src);
    dom_mask_t m;
    case (src)
      A_LB:     m = (dom_mask_t'(1) << D_TC) | (dom_mask_t'(1) << D_LB);
      A_DMA_TC: m = (dom_mask_t'(1) << D_DMA) | (dom_mask_t'(1) << D_TC) | (dom_mask_t'(1) << D_LB);
      A_DMA_BR: m = (dom_mask_t'(1) << D_TC) | (dom_mask_t'(1) << D_BRG) | (dom_mask_t'(1) << D_DMA);
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/iwk_irq_sync.sv
module iwk_irq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] irq_n_i,
  output logic [W-1:0] irq_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= irq_n_i;
      sync_q <= meta_q;
    end
  end

  assign irq_o = ~sync_q;
endmodule

// File: rtl/iwk_act_hold.sv
module iwk_act_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic keep_i,
  output logic en_o
);
  logic act_q;
  logic act_d;

  always_comb begin
    act_d = start_i | (act_q & keep_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign en_o = start_i | act_q;

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && !start_i && !keep_i) |=> (!en_o || start_i)); // R8
endmodule

// File: rtl/iwk_fsm.sv
module iwk_fsm
  import iwk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_mode_i,
  input  logic       idle_req_i,
  input  logic       pending_i,
  input  logic       host_irq_i,
  input  logic       dsp_irq_i,
  input  logic       ulp_wake_i,
  input  logic       hpi_en_i,
  output iwk_state_e state_o,
  output dom_mask_t  wake_mask_o,
  output logic       wake_full_o,
  output logic       clr_idle_o
);
  iwk_state_e state_q, state_d;
  dom_mask_t  mask_q, mask_d;
  logic       full_q, full_d;
  logic       load;

  always_comb begin
    state_d    = state_q;
    mask_d     = mask_q;
    full_d     = full_q;
    load       = 1'b0;
    clr_idle_o = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (idle_req_i && !pending_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (wake_mode_i && (host_irq_i || dsp_irq_i)) begin
          state_d    = ST_WAKE;
          load       = 1'b1;
          mask_d     = (host_irq_i ? M_HOST_IRQ : '0) |
                       (dsp_irq_i ? (M_DSP_IRQ | (hpi_en_i ? M_HPI : '0)) : '0);
          full_d     = 1'b0;
          clr_idle_o = host_irq_i;
        end else if (!wake_mode_i && ulp_wake_i) begin
          state_d    = ST_WAKE;
          load       = 1'b1;
          mask_d     = '1;
          full_d     = 1'b1;
          clr_idle_o = 1'b1;
        end
      end
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      mask_q <= mask_d;
      full_q <= full_d;
    end
  end

  assign state_o     = state_q;
  assign wake_mask_o = mask_q;
  assign wake_full_o = full_q;

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && idle_req_i && !pending_i) |=> (state_q == ST_IDLE)); // R3
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN)); // R6
  AST_EXT_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wake_mode_i && !ulp_wake_i) |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import iwk_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_i,
  input  logic [1:0]          host_wdata_i,
  input  logic                host_irq_n_i,
  input  logic                dsp_irq_n_i,
  input  logic                lb_act_i,
  input  logic                dma_tc_req_i,
  input  logic                dma_br_req_i,
  input  logic                dma_busy_i,
  input  logic                ulp_wake_i,
  input  logic                hpi_en_i,
  input  logic [N_PERIPH-1:0] periph_restore_i,
  output logic [DOM_W-1:0]    clk_en_o,
  output logic [N_PERIPH-1:0] periph_en_o,
  output logic [1:0]          state_o,
  output logic                idle_req_o,
  output logic                wake_mode_o
);
  localparam int N_IRQ = 2;

  logic             rst_meta_q, rst_sync_q, rst_n_s;
  logic [N_IRQ-1:0] irq_s;
  logic [N_ACT-1:0] act_start, act_keep, act_en;
  dom_mask_t        held_mask;
  logic             pending;
  logic             idle_req_q, wake_mode_q;
  iwk_state_e       state;
  dom_mask_t        wake_mask;
  logic             wake_full, clr_idle;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_s = rst_sync_q;

  iwk_irq_sync #(.W(N_IRQ)) u_irq_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .irq_n_i ({dsp_irq_n_i, host_irq_n_i}),
    .irq_o   (irq_s)
  );

  assign act_start = {dma_br_req_i, dma_tc_req_i, lb_act_i};
  assign act_keep  = {dma_busy_i, dma_busy_i, 1'b0};

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    iwk_act_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .start_i (act_start[g]),
      .keep_i  (act_keep[g]),
      .en_o    (act_en[g])
    );
  end

  always_comb begin
    held_mask = '0;
    for (int i = 0; i < N_ACT; i++) begin
      if (act_en[i]) held_mask = held_mask | act_mask(i);
    end
  end

  assign pending = (|irq_s) | (|act_en);

  // host-owned control bits
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idle_req_q  <= 1'b0;
      wake_mode_q <= 1'b0;
    end else begin
      if (host_wr_i) begin
        idle_req_q  <= host_wdata_i[0];
        wake_mode_q <= host_wdata_i[1];
      end else if (clr_idle) begin
        idle_req_q  <= 1'b0;
      end
    end
  end

  iwk_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wake_mode_i (wake_mode_q),
    .idle_req_i  (idle_req_q),
    .pending_i   (pending),
    .host_irq_i  (irq_s[0]),
    .dsp_irq_i   (irq_s[1]),
    .ulp_wake_i  (ulp_wake_i),
    .hpi_en_i    (hpi_en_i),
    .state_o     (state),
    .wake_mask_o (wake_mask),
    .wake_full_o (wake_full),
    .clr_idle_o  (clr_idle)
  );

  always_comb begin
    case (state)
      ST_RUN: begin
        clk_en_o    = '1;
        periph_en_o = '1;
      end
      ST_WAKE: begin
        clk_en_o    = wake_mask | held_mask;
        periph_en_o = wake_full ? '1 : periph_restore_i;
      end
      default: begin
        clk_en_o    = held_mask;
        periph_en_o = '0;
      end
    endcase
  end

  assign state_o     = state;
  assign idle_req_o  = idle_req_q;
  assign wake_mode_o = wake_mode_q;

  AST_HOST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_IDLE && irq_s[0] && wake_mode_q && !host_wr_i)
      |=> (state == ST_WAKE && !idle_req_q)); // R4
  AST_DSP_WAKE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_IDLE && irq_s[1] && !irq_s[0] && wake_mode_q && idle_req_q && !host_wr_i)
      |=> idle_req_q); // R5
endmodule

// File: tb/idle_wake_ctrl_tb.sv
`timescale 1ns/1ps
module idle_wake_ctrl_tb;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr_i;
  logic [1:0]    host_wdata_i;
  logic          host_irq_n_i, dsp_irq_n_i;
  logic          lb_act_i, dma_tc_req_i, dma_br_req_i, dma_busy_i;
  logic          ulp_wake_i, hpi_en_i;
  logic [NP-1:0] periph_restore_i;
  logic [8:0]    clk_en_o;
  logic [NP-1:0] periph_en_o;
  logic [1:0]    state_o;
  logic          idle_req_o, wake_mode_o;

  idle_wake_ctrl #(.N_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_irq_n_i(host_irq_n_i), .dsp_irq_n_i(dsp_irq_n_i), .lb_act_i(lb_act_i),
    .dma_tc_req_i(dma_tc_req_i), .dma_br_req_i(dma_br_req_i), .dma_busy_i(dma_busy_i),
    .ulp_wake_i(ulp_wake_i), .hpi_en_i(hpi_en_i), .periph_restore_i(periph_restore_i),
    .clk_en_o(clk_en_o), .periph_en_o(periph_en_o), .state_o(state_o),
    .idle_req_o(idle_req_o), .wake_mode_o(wake_mode_o)
  );

  always #5 clk = ~clk;

  localparam logic [1:0] RUN = 2'd0, IDL = 2'd1, WAK = 2'd2;

  typedef struct {
    int         cyc;
    string      req;
    logic [8:0] en;
    logic [3:0] pe;
    logic [1:0] st;
    logic       idl;
    logic       md;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int k, string r, logic [8:0] en, logic [3:0] pe,
                           logic [1:0] st, logic idl, logic md);
    exp_t e;
    e.cyc = cyc + k; e.req = r; e.en = en; e.pe = pe; e.st = st; e.idl = idl; e.md = md;
    q.push_back(e);
  endtask

  // monitor: samples between the falling and the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (clk_en_o !== e.en || periph_en_o !== e.pe || state_o !== e.st ||
            idle_req_o !== e.idl || wake_mode_o !== e.md) begin
          n_bad++;
          $display("FAIL %s cyc=%0d actual en=%h pe=%h st=%0d idl=%b md=%b expected en=%h pe=%h st=%0d idl=%b md=%b",
                   e.req, cyc, clk_en_o, periph_en_o, state_o, idle_req_o, wake_mode_o,
                   e.en, e.pe, e.st, e.idl, e.md);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still busy at cyc=%0d, expected finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr_i = 1'b0; host_wdata_i = 2'b00;
    host_irq_n_i = 1'b1; dsp_irq_n_i = 1'b1; lb_act_i = 1'b0;
    dma_tc_req_i = 1'b0; dma_br_req_i = 1'b0; dma_busy_i = 1'b0;
    ulp_wake_i = 1'b0; hpi_en_i = 1'b0; periph_restore_i = 4'b0101;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    expect_at(0, "R1", 9'h1FF, 4'hF, RUN, 1'b0, 1'b0);
    tick(1);

    // R2 / R3: request idle with wake-mode 1
    host_wr_i = 1'b1; host_wdata_i = 2'b11;
    expect_at(1, "R2", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    expect_at(2, "R3", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(1); host_wr_i = 1'b0;
    tick(3);

    // R4 host interrupt wake, then R6
    host_irq_n_i = 1'b0;
    expect_at(2, "R4", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    expect_at(3, "R4", 9'h01F, 4'h5, WAK, 1'b0, 1'b1);
    expect_at(4, "R6", 9'h1FF, 4'hF, RUN, 1'b0, 1'b1);
    tick(5); host_irq_n_i = 1'b1;
    tick(3);

    // R3: pending bus activity blocks idle entry
    lb_act_i = 1'b1;
    tick(1);
    host_wr_i = 1'b1; host_wdata_i = 2'b11;
    expect_at(3, "R3", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    tick(1); host_wr_i = 1'b0;
    tick(3);
    lb_act_i = 1'b0;
    expect_at(1, "R3", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    expect_at(2, "R3", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(3);

    // R5 DSP wake with host-port enable set; held irq keeps RUN
    hpi_en_i = 1'b1; dsp_irq_n_i = 1'b0;
    expect_at(3, "R5", 9'h1D0, 4'h5, WAK, 1'b1, 1'b1);
    expect_at(4, "R6", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    expect_at(6, "R5", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    tick(7); dsp_irq_n_i = 1'b1;
    expect_at(2, "R3", 9'h1FF, 4'hF, RUN, 1'b1, 1'b1);
    expect_at(3, "R3", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(4);

    // R5 DSP wake with host-port enable clear
    hpi_en_i = 1'b0; dsp_irq_n_i = 1'b0;
    expect_at(3, "R5", 9'h0D0, 4'h5, WAK, 1'b1, 1'b1);
    tick(5); dsp_irq_n_i = 1'b1;
    expect_at(3, "R5", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(4);

    // R8 local-bus hold
    lb_act_i = 1'b1;
    expect_at(0, "R8", 9'h030, 4'h0, IDL, 1'b1, 1'b1);
    expect_at(2, "R8", 9'h030, 4'h0, IDL, 1'b1, 1'b1);
    tick(3); lb_act_i = 1'b0;
    expect_at(0, "R8", 9'h030, 4'h0, IDL, 1'b1, 1'b1);
    expect_at(1, "R8", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(2);

    // R9 DMA from traffic controller
    dma_tc_req_i = 1'b1; dma_busy_i = 1'b1;
    expect_at(0, "R9", 9'h038, 4'h0, IDL, 1'b1, 1'b1);
    tick(1); dma_tc_req_i = 1'b0;
    expect_at(2, "R9", 9'h038, 4'h0, IDL, 1'b1, 1'b1);
    tick(3); dma_busy_i = 1'b0;
    expect_at(0, "R9", 9'h038, 4'h0, IDL, 1'b1, 1'b1);
    expect_at(1, "R9", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(2);

    // R10 DMA from peripheral bridge
    dma_br_req_i = 1'b1; dma_busy_i = 1'b1;
    expect_at(0, "R10", 9'h01C, 4'h0, IDL, 1'b1, 1'b1);
    tick(1); dma_br_req_i = 1'b0;
    expect_at(2, "R10", 9'h01C, 4'h0, IDL, 1'b1, 1'b1);
    tick(3); dma_busy_i = 1'b0;
    expect_at(1, "R10", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(2);

    // R7 external strobe ignored in wake-mode 1
    ulp_wake_i = 1'b1;
    expect_at(1, "R7", 9'h000, 4'h0, IDL, 1'b1, 1'b1);
    tick(1); ulp_wake_i = 1'b0;
    tick(2);

    // R2 / R7: switch to wake-mode 0, interrupt ignored, strobe wakes
    host_wr_i = 1'b1; host_wdata_i = 2'b01;
    expect_at(1, "R2", 9'h000, 4'h0, IDL, 1'b1, 1'b0);
    tick(1); host_wr_i = 1'b0;
    tick(2);
    host_irq_n_i = 1'b0;
    expect_at(3, "R7", 9'h000, 4'h0, IDL, 1'b1, 1'b0);
    expect_at(5, "R7", 9'h000, 4'h0, IDL, 1'b1, 1'b0);
    tick(6); host_irq_n_i = 1'b1;
    tick(3);
    ulp_wake_i = 1'b1;
    expect_at(1, "R7", 9'h1FF, 4'hF, WAK, 1'b0, 1'b0);
    expect_at(2, "R6", 9'h1FF, 4'hF, RUN, 1'b0, 1'b0);
    tick(1); ulp_wake_i = 1'b0;
    tick(4);

    wait (q.size() == 0);
    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule